// File: doc/BRIEF.md
# Reset Release and Vector Fetch Sequencer

This block brings a small 8-bit processor out of reset. It watches an active-low reset pin and passes it through a two-flop synchroniser clocked by the oscillator. A low level only counts as a valid reset once it has lasted a minimum number of oscillator cycles. When a valid reset is released, the block keeps the core's internal reset asserted for an oscillator-settling delay. That delay comes from a divide-by-16 prescaler driving two chained 8-bit down-counters.

After the delay the block runs the start-up bus cycles at the processor clock, which is half the oscillator rate, so every bus cycle lasts two oscillator clocks. The first three cycles touch the stack page and write nothing. The next two fetch the reset vector, low byte first. The last is a first opcode fetch from the loaded program counter, marked by a sync strobe. Memory sits outside the block as a combinational read port. The processor status byte comes out with only the interrupt-disable flag set. A new low on the pin at any point throws the block back to its start.

Top module: `reset_vector_seq`

## Requirements
- R1: A low on the reset pin, once it has passed through the two-flop synchroniser, returns the block to its held-reset state from any phase (delay, bus cycles or run). In that state `int_rst_o` is 1 and the counters reload their presets.
- R2: If the synchronised pin was low for fewer than MIN_LOW_CYC oscillator cycles (default 16) before rising, `int_rst_o` stays 1 and the bus stays idle until a low of sufficient length ends.
- R3: After a valid low, `int_rst_o` stays 1 for exactly 32768 oscillator clocks (16 × 256 × 8) once the synchronised pin reads high. With the pin rising between two clock edges, `int_rst_o` falls on the 32771st rising edge after the rise.
- R4: After release come three bus cycles of two oscillator clocks each, with `rd_o`=1 and `sync_o`=0. Their addresses are {0x00, S}, {0x00, S-1} and {0x00, S-2} in that order, taken modulo 256, where S is `stack_ptr`.
- R5: Next come two read cycles of two clocks each, with `rd_o`=1: address 0xFFFE, then address 0xFFFF.
- R6: The byte read at 0xFFFE becomes `pc_o[7:0]` and the byte read at 0xFFFF becomes `pc_o[15:8]`. `pc_o` holds that value afterwards.
- R7: The sixth bus cycle drives `addr_o`=`pc_o` with `rd_o`=1 and `sync_o`=1 for exactly two clocks. After it, `sync_o` and `rd_o` are 0 and `addr_o` stays at `pc_o`.
- R8: `status_o` is always 0x04: bit 2 is the interrupt-disable flag at 1, and every other bit is 0.
- R9: While `int_rst_o` is 1, `rd_o`=0, `sync_o`=0, `addr_o`=0 and `pc_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| stack_ptr | input | 8 | Current stack pointer low byte |
| rdata | input | 8 | Read data from memory for `addr_o` |
| int_rst_o | output | 1 | Internal reset to the core, active high |
| sync_o | output | 1 | Opcode fetch strobe |
| rd_o | output | 1 | Bus read strobe |
| addr_o | output | 16 | Bus address |
| pc_o | output | 16 | Program counter loaded from the vector |
| status_o | output | 8 | Processor status byte at reset |

## Verification
Two situations are hard to reach from the ports: a pin low that arrives in the middle of the bus cycles, and one that arrives deep inside the 32768-clock delay. Either one is only reachable after a full settling run. The stimulus drives a clean start first, then a short glitch that must leave the block stuck in reset. It then releases a valid low and cuts it off 10000 clocks into the delay. After that it lets a delay finish and pulls the pin low during the second stack cycle. A stack value of 0x01 makes the third stack address wrap to 0x00FF.

// File: rtl/reset_vector_seq.sv
module reset_vector_seq #(
  parameter int          MIN_LOW_CYC = 16,
  parameter int          PRESCALE    = 16,
  parameter logic [7:0]  LO_PRESET   = 8'hFF,
  parameter logic [7:0]  HI_PRESET   = 8'h07,
  parameter logic [15:0] VEC_ADDR    = 16'hFFFE
) (
  input  logic        clk_osc,
  input  logic        rst_pin_n,
  input  logic [7:0]  stack_ptr,
  input  logic [7:0]  rdata,
  output logic        int_rst_o,
  output logic        sync_o,
  output logic        rd_o,
  output logic [15:0] addr_o,
  output logic [15:0] pc_o,
  output logic [7:0]  status_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int LW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(MIN_LOW_CYC);
  localparam logic [PW-1:0] PRE_END = PW'(PRESCALE - 1);
  localparam logic [7:0] STATUS_RST = 8'h04;

  typedef enum logic [2:0] {
    S_HOLD, S_DELAY, S_STK, S_VLO, S_VHI, S_FETCH, S_RUN
  } st_t;

  st_t           st;
  logic          s1, s2, ph;
  logic [LW-1:0] low_q;
  logic [PW-1:0] pre;
  logic [7:0]    lo, hi;
  logic [1:0]    stk;
  logic [15:0]   pc;

  always_ff @(posedge clk_osc or negedge rst_pin_n)
    if (!rst_pin_n) {s2, s1} <= 2'b00;
    else            {s2, s1} <= {s1, 1'b1};

  always_ff @(posedge clk_osc) begin
    if (!s2) begin
      st    <= S_HOLD;
      low_q <= (low_q == LOW_MAX) ? low_q : low_q + LW'(1);
      ph    <= 1'b0;
      pre   <= '0;
      lo    <= LO_PRESET;
      hi    <= HI_PRESET;
      stk   <= 2'd0;
      pc    <= 16'h0000;
    end else begin
      case (st)
        S_HOLD: begin
          low_q <= '0;
          if (low_q >= LOW_MAX) st <= S_DELAY;
        end
        S_DELAY: begin
          pre <= pre + PW'(1);
          if (pre == PRE_END) begin
            pre <= '0;
            if (lo != 8'd0)      lo <= lo - 8'd1;
            else if (hi == 8'd0) st <= S_STK;
            else begin
              lo <= LO_PRESET;
              hi <= hi - 8'd1;
            end
          end
        end
        S_RUN: ph <= 1'b0;
        default: begin
          ph <= ~ph;
          if (ph) begin
            case (st)
              S_STK: if (stk == 2'd2) st <= S_VLO; else stk <= stk + 2'd1;
              S_VLO: begin pc[7:0]  <= rdata; st <= S_VHI;   end
              S_VHI: begin pc[15:8] <= rdata; st <= S_FETCH; end
              default: st <= S_RUN;
            endcase
          end
        end
      endcase
    end
  end

  assign int_rst_o = (st == S_HOLD) || (st == S_DELAY);
  assign rd_o      = (st == S_STK) || (st == S_VLO) || (st == S_VHI) || (st == S_FETCH);
  assign sync_o    = (st == S_FETCH);
  assign pc_o      = pc;
  assign status_o  = STATUS_RST;

  always_comb begin
    case (st)
      S_STK:          addr_o = {8'h00, stack_ptr - {6'd0, stk}};
      S_VLO:          addr_o = VEC_ADDR;
      S_VHI:          addr_o = VEC_ADDR + 16'd1;
      S_FETCH, S_RUN: addr_o = pc;
      default:        addr_o = 16'h0000;
    endcase
  end

  assert_pin_low_holds_R1: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    !s2 |=> int_rst_o);
  assert_short_low_stays_R2: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    (st == S_HOLD && s2 && low_q < LOW_MAX) |=> (st == S_HOLD));
  assert_release_on_overflow_R3: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    $fell(int_rst_o) |-> ($past(hi) == 8'd0 && $past(lo) == 8'd0 && $past(pre) == PRE_END));
  assert_first_stack_cycle_R4: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    $fell(int_rst_o) |-> (rd_o && addr_o == {8'h00, stack_ptr}));
  assert_vector_high_follows_R5: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    (st == S_VLO && ph && s2) |=> (addr_o == VEC_ADDR + 16'd1));
  assert_pc_high_loaded_R6: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    (st == S_VHI && ph && s2) |=> (pc_o[15:8] == $past(rdata)));
  assert_sync_at_pc_R7: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    $rose(sync_o) |-> (addr_o == pc_o && rd_o));
  assert_sync_two_clocks_R7: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    (sync_o && $past(sync_o) && s2) |=> !sync_o);
  assert_bus_quiet_in_reset_R9: assert property (@(posedge clk_osc) disable iff (!rst_pin_n)
    int_rst_o |-> (!rd_o && !sync_o && pc_o == 16'h0000));
endmodule

// File: tb/reset_vector_seq_test.sv
module reset_vector_seq_test;
  localparam int MIN_LOW = 16;
  localparam int DELAY   = 32768;

  logic        clk = 1'b0;
  logic        pin = 1'b0;
  logic [7:0]  sp  = 8'h80;
  logic [7:0]  rdata;
  logic [7:0]  vlo = 8'h34, vhi = 8'h12;
  logic        int_rst, sync, rd;
  logic [15:0] addr, pc;
  logic [7:0]  status;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  reset_vector_seq uut (
    .clk_osc(clk), .rst_pin_n(pin), .stack_ptr(sp), .rdata(rdata),
    .int_rst_o(int_rst), .sync_o(sync), .rd_o(rd), .addr_o(addr),
    .pc_o(pc), .status_o(status));

  function automatic logic [7:0] mem(input logic [15:0] a);
    if (a == 16'hFFFE) return vlo;
    if (a == 16'hFFFF) return vhi;
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rdata = mem(addr);

  // reference model: 0 held, 1 delay, 2 bus, 3 run
  int          m_mode = 0, m_low = 0, m_left = 0, m_step = 0;
  logic        m_s1 = 1'b0, m_s2 = 1'b0, sync_now;
  logic [15:0] m_pc = 16'h0000;

  always @(posedge clk) begin
    cyc++;
    sync_now = pin ? m_s2 : 1'b0;
    if (!sync_now) begin
      m_mode = 0;
      m_low  = (m_low < MIN_LOW) ? m_low + 1 : m_low;
      m_pc   = 16'h0000;
    end else if (m_mode == 0) begin
      if (m_low >= MIN_LOW) begin m_mode = 1; m_left = DELAY; end
      m_low = 0;
    end else if (m_mode == 1) begin
      m_left--;
      if (m_left == 0) begin m_mode = 2; m_step = 0; end
    end else if (m_mode == 2) begin
      if (m_step == 7) m_pc[7:0]  = mem(16'hFFFE);
      if (m_step == 9) m_pc[15:8] = mem(16'hFFFF);
      m_step++;
      if (m_step == 12) m_mode = 3;
    end
    m_s2 = pin ? m_s1 : 1'b0;
    m_s1 = pin;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cyc >= 2) begin
      logic [15:0] e_addr;
      logic        e_rd, e_sync, e_rst;
      string       tag;
      int          bc;
      bc = m_step / 2;
      e_rst = (m_mode <= 1);
      e_rd = (m_mode == 2);
      e_sync = (m_mode == 2 && bc == 5);
      if (m_mode <= 1) begin e_addr = 16'h0000; tag = (m_mode == 0) ? "R1" : "R3"; end
      else if (m_mode == 3) begin e_addr = m_pc; tag = "R7"; end
      else if (bc < 3) begin e_addr = {8'h00, sp - 8'(bc)}; tag = "R4"; end
      else if (bc < 5) begin e_addr = (bc == 3) ? 16'hFFFE : 16'hFFFF; tag = "R5"; end
      else begin e_addr = m_pc; tag = "R7"; end
      chk(int_rst == e_rst, {tag, " int_rst"}, 32'(int_rst), 32'(e_rst));
      chk(rd == e_rd, {tag, " rd"}, 32'(rd), 32'(e_rd));
      chk(sync == e_sync, {tag, " sync"}, 32'(sync), 32'(e_sync));
      chk(addr == e_addr, {tag, " addr"}, 32'(addr), 32'(e_addr));
      chk(status == 8'h04, "R8 status", 32'(status), 32'h04);
      if (m_mode <= 1) chk(pc == 16'h0000, "R9 pc in reset", 32'(pc), 0);
      if (m_mode == 3 || (m_mode == 2 && bc == 5))
        chk(pc == m_pc, "R6 pc", 32'(pc), 32'(m_pc));
    end
  end

  always @(posedge clk)
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_low(input int n);
    pin = 1'b0;
    cycles(n);
    pin = 1'b1;
  endtask

  initial begin
    int hi_cnt;
    cycles(40);
    chk(int_rst == 1'b1 && rd == 1'b0, "R9 reset state", 32'(int_rst), 1);
    // R3: count clocks of internal reset after pin rise
    pin = 1'b1;
    hi_cnt = 0;
    while (int_rst && hi_cnt < 40000) begin cycles(1); if (int_rst) hi_cnt++; end
    chk(hi_cnt == DELAY + 2, "R3 delay length", 32'(hi_cnt), 32'(DELAY + 2));
    wait (m_mode == 3);
    cycles(30);
    chk(pc == 16'h1234, "R6 vector run 1", 32'(pc), 32'h1234);

    // R2: glitch shorter than the minimum low time
    pulse_low(5);
    cycles(300);
    chk(int_rst == 1'b1, "R2 glitch keeps reset", 32'(int_rst), 1);
    chk(rd == 1'b0, "R2 bus idle", 32'(rd), 0);

    // R1: valid low, then a new low deep in the delay
    sp = 8'h01; vlo = 8'hCD; vhi = 8'hAB;
    pulse_low(30);
    cycles(10000);
    chk(int_rst == 1'b1, "R3 still in delay", 32'(int_rst), 1);
    pulse_low(20);

    // R1: abort during the second stack cycle
    wait (m_mode == 2 && m_step == 3);
    cycles(1);
    pin = 1'b0;
    cycles(3);
    chk(int_rst == 1'b1 && rd == 1'b0, "R1 abort in bus", 32'(int_rst), 1);
    cycles(22);
    pin = 1'b1;
    wait (m_mode == 3);
    cycles(30);
    chk(pc == 16'hABCD, "R6 vector run 2", 32'(pc), 32'hABCD);
    chk(sync == 1'b0 && rd == 1'b0, "R7 idle after fetch", 32'({sync, rd}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule